// File: doc/BRIEF.md
# Ethernet Start-Lane Realigner

The realigner sits on the receive path after line decoding. It takes a 10G Ethernet character stream of one beat per clock: eight byte lanes, each carrying eight data bits and one control flag. It produces a stream in which every Start character arrives in lane 0 of an output beat. Each lane is classified as Start, Terminate or Idle. Two locators find the lowest Start lane and the lowest Terminate lane of the beat. The aligner then shifts the stream by whole byte lanes and keeps the bytes that spill past the end of an output beat in a residue register.

When a Start arrives, the bytes held in the residue and the bytes in front of the Start are closed off into one output beat. That beat is padded with idles when the closing bytes are fewer than eight. When they are more than eight, the idles nearest the Start are dropped. The shift then stays fixed until the next Start. A counter keeps the net number of idles dropped. During a gap between frames, when no input beat arrives, the block writes whole idle beats and subtracts them from that counter. Realigned beats go into an output FIFO. The FIFO reports full and empty, has a registered read port, and records a sticky overflow error.

Top module: `start_lane_realigner`

## Requirements
- R1: After a synchronous reset the FIFO is empty (`fifo_empty`=1, `fifo_full`=0), `overflow_err` is 0, `out_valid` is 0, the shift is zero and the idle-loss count is zero.
- R2: Lane i is `in_data[8i+7:8i]` with control flag `in_ctrl[i]`, and lane 0 is first in time. Start is 0xFB, Terminate is 0xFD and Idle is 0x07, each only with its control flag at 1. A data byte 0xFB with its flag at 0 is plain data.
- R3: Until the first Start after reset, each valid beat is written to the FIFO unchanged.
- R4: A valid beat with its lowest Start in lane p, with k residue bytes held, writes one beat made of the residue bytes followed by input lanes 0..p-1. This beat is cut to 8 lanes or padded at the end with Idles. Lanes p..7 become the new residue (k=8-p), so the next written beat carries the Start in lane 0.
- R5: A valid beat without a Start writes the k residue bytes followed by input lanes 0..7-k. Input lanes 8-k..7 become the residue, so the shift is held between Starts. With a Start in lane 0 the shift is 8, which means a one-beat delay.
- R6: At each Start the idle-loss count gains max(0, k+p-8) and then loses max(0, 8-k-p), floored at 0.
- R7: A cycle with `in_valid`=0 is a replay cycle when a Terminate has been seen since the last Start (or no Start since reset), all residue bytes are Idle, and the idle-loss count is non-zero. A replay cycle writes one all-Idle beat and lowers the count by 8, floored at 0.
- R8: A cycle with `in_valid`=0 that is not a replay cycle writes nothing.
- R9: The FIFO keeps beats in order. Asserting `rd_en` while it is non-empty gives `out_valid`=1 in the next cycle, with the oldest beat on `out_data`/`out_ctrl` (ctrl bit i for lane i).
- R10: `fifo_full` is 1 while FIFO_DEPTH beats are stored. A write while full is dropped and sets `overflow_err`, which stays 1 until reset.
- R11: `rd_en` on an empty FIFO has no effect: `out_valid` is 0 in the next cycle and the stored beats are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present this cycle |
| in_data | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| in_ctrl | input | 8 | Control flag per lane |
| rd_en | input | 1 | FIFO read request |
| out_valid | output | 1 | Read data valid (one cycle after an accepted read) |
| out_data | output | 64 | Realigned byte lanes |
| out_ctrl | output | 8 | Realigned control flags |
| fifo_empty | output | 1 | FIFO holds no beat |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH beats |
| overflow_err | output | 1 | Sticky flag for a write dropped while full |

## Verification
The idle-plus-data stream before any Start shows whether the zero-shift path is a true pass-through. Frames whose Start lanes and lengths produce closing counts below, at and above eight separate the padding path from the dropping path and from the held shift. A data byte of value 0xFB checks that the classifier uses the control flag. Gaps with no input after a frame that lost idles, and gaps inside an open frame, separate a replay from a forbidden write. A read-stalled burst and reads on an empty FIFO exercise the full, empty and sticky overflow behaviour.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int LANES  = 8;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int IDX_W  = $clog2(LANES);
  localparam int KW     = $clog2(LANES + 1);

  localparam logic [BYTE_W-1:0] START_CODE = 8'hFB;
  localparam logic [BYTE_W-1:0] TERM_CODE  = 8'hFD;
  localparam logic [BYTE_W-1:0] IDLE_CODE  = 8'h07;

  typedef struct packed {
    logic              c;
    logic [BYTE_W-1:0] d;
  } lane_t;

  localparam lane_t IDLE_LANE  = '{c: 1'b1, d: IDLE_CODE};
  localparam lane_t START_LANE = '{c: 1'b1, d: START_CODE};
endpackage

// File: rtl/slr_lane_detect.sv
module slr_lane_detect
  import slr_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  ctrl,
  output logic [LANES-1:0]  is_start,
  output logic [LANES-1:0]  is_term,
  output logic [LANES-1:0]  is_idle
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] b;
    assign b           = data[g*BYTE_W +: BYTE_W];
    assign is_start[g] = ctrl[g] && (b == START_CODE);
    assign is_term[g]  = ctrl[g] && (b == TERM_CODE);
    assign is_idle[g]  = ctrl[g] && (b == IDLE_CODE);
  end
endmodule

// File: rtl/slr_first_lane.sv
module slr_first_lane #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  flags,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags[i]) idx = IW'(i);
    end
  end
  assign found = |flags;
endmodule

// File: rtl/slr_aligner.sv
module slr_aligner
  import slr_pkg::*;
#(
  parameter int LOSS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_ctrl,
  input  logic              st_found,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              tm_found,
  input  logic [IDX_W-1:0]  tm_idx,
  input  logic [LANES-1:0]  id_flags,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_ctrl
);
  localparam int CAT      = 2 * LANES;
  localparam int LOSS_MAX = (1 << LOSS_W) - 1;

  lane_t             res_q [LANES];
  logic [LANES-1:0]  res_idle_q;
  logic [KW-1:0]     k_q;
  logic [LOSS_W-1:0] loss_q;
  logic              in_frame_q;

  lane_t             beat  [LANES];
  lane_t             cat   [CAT];
  logic [CAT-1:0]    cat_idle;
  lane_t             out_b [LANES];
  lane_t             res_s [LANES];
  logic [LANES-1:0]  res_s_idle;
  logic              res_all_idle;
  logic              replay;
  logic              tail_idle;
  logic [LOSS_W-1:0] loss_start;
  logic [LOSS_W-1:0] loss_replay;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      beat[i].c = in_ctrl[i];
      beat[i].d = in_data[i*BYTE_W +: BYTE_W];
    end
    // residue bytes first, then the input beat, then idle filler
    for (int i = 0; i < CAT; i++) begin
      int b;
      b = i - int'(k_q);
      if (i < int'(k_q)) begin
        cat[i]      = res_q[i[IDX_W-1:0]];
        cat_idle[i] = res_idle_q[i[IDX_W-1:0]];
      end else if (b < LANES) begin
        cat[i]      = beat[b[IDX_W-1:0]];
        cat_idle[i] = id_flags[b[IDX_W-1:0]];
      end else begin
        cat[i]      = IDLE_LANE;
        cat_idle[i] = 1'b1;
      end
    end
  end

  always_comb begin
    int cut, t;
    cut = int'(k_q) + int'(st_idx);
    for (int j = 0; j < LANES; j++) begin
      if (!in_valid)     out_b[j] = IDLE_LANE;
      else if (!st_found) out_b[j] = cat[j];
      else if (j < cut)  out_b[j] = cat[j];
      else               out_b[j] = IDLE_LANE;
    end
    for (int i = 0; i < LANES; i++) begin
      int b;
      b = i + int'(st_idx);
      if (b < LANES) begin
        res_s[i]      = beat[b[IDX_W-1:0]];
        res_s_idle[i] = id_flags[b[IDX_W-1:0]];
      end else begin
        res_s[i]      = IDLE_LANE;
        res_s_idle[i] = 1'b1;
      end
    end
    t = int'(loss_q);
    if (cut > LANES) t = t + (cut - LANES);
    if (t > LOSS_MAX) t = LOSS_MAX;
    if (cut < LANES) t = t - (LANES - cut);
    if (t < 0) t = 0;
    loss_start = t[LOSS_W-1:0];
    t = int'(loss_q) - LANES;
    if (t < 0) t = 0;
    loss_replay = t[LOSS_W-1:0];
  end

  always_comb begin
    res_all_idle = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(k_q) && !res_idle_q[i]) res_all_idle = 1'b0;
    end
    tail_idle = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (i > int'(tm_idx) && !id_flags[i]) tail_idle = 1'b0;
    end
  end

  assign replay = !in_valid && !in_frame_q && (loss_q != '0) && res_all_idle;
  assign wr_en  = in_valid || replay;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign wr_data[g*BYTE_W +: BYTE_W] = out_b[g].d;
    assign wr_ctrl[g]                  = out_b[g].c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q        <= '0;
      loss_q     <= '0;
      in_frame_q <= 1'b0;
      res_idle_q <= '1;
      for (int i = 0; i < LANES; i++) res_q[i] <= IDLE_LANE;
    end else if (in_valid && st_found) begin
      k_q        <= KW'(LANES) - KW'(st_idx);
      loss_q     <= loss_start;
      in_frame_q <= 1'b1;
      res_idle_q <= res_s_idle;
      for (int i = 0; i < LANES; i++) res_q[i] <= res_s[i];
    end else if (in_valid) begin
      if (tm_found) in_frame_q <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        res_q[i]      <= cat[LANES + i];
        res_idle_q[i] <= cat_idle[LANES + i];
      end
    end else if (replay) begin
      loss_q <= loss_replay;
    end
  end

  // R4
  start_to_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && st_found |=> (res_q[0] == START_LANE) && (k_q == KW'(LANES) - KW'($past(st_idx))));
  // R5
  shift_range_chk: assert property (@(posedge clk) disable iff (rst)
    k_q <= KW'(LANES));
  // R7
  replay_drains_chk: assert property (@(posedge clk) disable iff (rst)
    replay |=> loss_q < $past(loss_q));
  // R2
  term_tail_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && tm_found && !st_found |-> tail_idle);
endmodule

// File: rtl/slr_fifo.sv
module slr_fifo #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (wr_en && full) overflow <= 1'b1;
      if (wr_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R11
  valid_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en) && !$past(empty));
  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/start_lane_realigner.sv
module start_lane_realigner
  import slr_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LOSS_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_ctrl,
  input  logic              rd_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_ctrl,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              overflow_err
);
  localparam int WORD_W = DATA_W + LANES;

  logic [LANES-1:0]  st_flags, tm_flags, id_flags;
  logic [IDX_W-1:0]  st_idx, tm_idx;
  logic              st_found, tm_found;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [LANES-1:0]  wr_ctrl;
  logic [WORD_W-1:0] rd_word;

  slr_lane_detect u_detect (
    .data(in_data), .ctrl(in_ctrl),
    .is_start(st_flags), .is_term(tm_flags), .is_idle(id_flags)
  );

  slr_first_lane #(.N(LANES)) u_start_loc (
    .flags(st_flags), .idx(st_idx), .found(st_found)
  );

  slr_first_lane #(.N(LANES)) u_term_loc (
    .flags(tm_flags), .idx(tm_idx), .found(tm_found)
  );

  slr_aligner #(.LOSS_W(LOSS_W)) u_align (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl),
    .st_found(st_found), .st_idx(st_idx), .tm_found(tm_found), .tm_idx(tm_idx),
    .id_flags(id_flags), .wr_en(wr_en), .wr_data(wr_data), .wr_ctrl(wr_ctrl)
  );

  slr_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data({wr_ctrl, wr_data}),
    .rd_en(rd_en), .rd_valid(out_valid), .rd_data(rd_word),
    .full(fifo_full), .empty(fifo_empty), .overflow(overflow_err)
  );

  assign out_data = rd_word[DATA_W-1:0];
  assign out_ctrl = rd_word[WORD_W-1:DATA_W];
endmodule

// File: tb/sim_start_lane_realigner.sv
`timescale 1ns/1ps
module sim_start_lane_realigner;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        rd_en = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        fifo_empty, fifo_full, overflow_err;

  always #2.5 clk = ~clk;

  start_lane_realigner #(.FIFO_DEPTH(DEPTH), .LOSS_W(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl),
    .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow_err(overflow_err)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    armed = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam logic [8:0] B_IDLE = 9'h107;
  localparam logic [8:0] B_S    = 9'h1FB;
  localparam logic [8:0] B_T    = 9'h1FD;

  logic [8:0]  mres[$];
  logic [71:0] mfifo[$];
  int          mloss;
  bit          mframe;
  bit          mvalid;
  logic [71:0] mrd;
  bit          movf;

  function automatic logic [71:0] pack8(logic [8:0] b[8]);
    logic [71:0] w;
    for (int i = 0; i < 8; i++) begin
      w[8*i +: 8] = b[i][7:0];
      w[64 + i]   = b[i][8];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    logic [8:0]  bb[8];
    logic [8:0]  ob[8];
    logic [8:0]  tmp[$];
    bit          do_wr, full0, empty0, tm, allid;
    int          p, cut;
    if (rst) begin
      mres.delete(); mfifo.delete();
      mloss = 0; mframe = 0; mvalid = 0; movf = 0;
      armed = 1;
    end else begin
      full0  = (mfifo.size() == DEPTH);
      empty0 = (mfifo.size() == 0);
      do_wr  = 0;
      if (in_valid) begin
        p = -1; tm = 0;
        for (int i = 0; i < 8; i++) begin
          bb[i] = {in_ctrl[i], in_data[8*i +: 8]};
          if (bb[i] == B_S && p < 0) p = i;
          if (bb[i] == B_T) tm = 1;
        end
        tmp = mres;
        do_wr = 1;
        if (p >= 0) begin
          for (int i = 0; i < p; i++) tmp.push_back(bb[i]);
          cut = tmp.size();
          for (int j = 0; j < 8; j++) ob[j] = (tmp.size() > 0) ? tmp.pop_front() : B_IDLE;
          if (cut > 8) mloss = mloss + (cut - 8);
          if (mloss > 255) mloss = 255;
          if (cut < 8) mloss = mloss - (8 - cut);
          if (mloss < 0) mloss = 0;
          mres.delete();
          for (int i = p; i < 8; i++) mres.push_back(bb[i]);
          mframe = 1;
        end else begin
          for (int i = 0; i < 8; i++) tmp.push_back(bb[i]);
          for (int j = 0; j < 8; j++) ob[j] = tmp.pop_front();
          mres = tmp;
          if (tm) mframe = 0;
        end
      end else begin
        allid = 1;
        foreach (mres[i]) if (mres[i] != B_IDLE) allid = 0;
        if (!mframe && mloss > 0 && allid) begin
          for (int j = 0; j < 8; j++) ob[j] = B_IDLE;
          do_wr = 1;
          mloss = (mloss > 8) ? mloss - 8 : 0;
        end
      end
      if (rd_en && !empty0) begin
        mrd = mfifo.pop_front();
        mvalid = 1;
      end else begin
        mvalid = 0;
      end
      if (do_wr) begin
        if (!full0) mfifo.push_back(pack8(ob));
        else movf = 1;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(fifo_empty == (mfifo.size() == 0), "R9", "fifo_empty", 72'(fifo_empty), 72'(mfifo.size() == 0));
      chk(fifo_full == (mfifo.size() == DEPTH), "R10", "fifo_full", 72'(fifo_full), 72'(mfifo.size() == DEPTH));
      chk(overflow_err == movf, "R10", "overflow_err", 72'(overflow_err), 72'(movf));
      chk(out_valid == mvalid, "R11", "out_valid", 72'(out_valid), 72'(mvalid));
      if (mvalid && out_valid)
        chk({out_ctrl, out_data} == mrd, cur_req, "out beat", {out_ctrl, out_data}, mrd);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [8:0] bq[$];

  task automatic add_idles(int n);
    for (int i = 0; i < n; i++) bq.push_back(B_IDLE);
  endtask

  task automatic add_frame(int pre, int len);
    add_idles(pre);
    bq.push_back(B_S);
    for (int i = 0; i < len; i++)
      bq.push_back((i == 0) ? 9'h0FB : {1'b0, 8'((i * 29 + len) & 255)});
    bq.push_back(B_T);
    add_idles(12);
  endtask

  task automatic send_full();
    while (bq.size() >= 8) begin
      for (int i = 0; i < 8; i++) begin
        logic [8:0] b;
        b = bq.pop_front();
        in_ctrl[i]      = b[8];
        in_data[8*i +: 8] = b[7:0];
      end
      in_valid = 1;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic gap(int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    // R1 explicit reset-state check
    chk(fifo_empty && !fifo_full && !overflow_err && !out_valid, "R1", "reset state",
        {68'd0, fifo_empty, fifo_full, overflow_err, out_valid}, 72'b1000);
    rst = 0;
    rd_en = 1;

    cur_req = "R3";
    add_idles(24);
    for (int i = 0; i < 8; i++) bq.push_back({1'b0, 8'(8'hFB - i * 17)});
    add_idles(8);
    send_full();
    gap(2);

    cur_req = "R4";
    add_frame(5, 20);
    send_full();
    gap(3);

    cur_req = "R5";
    add_frame(1, 9);
    add_frame(6, 30);
    send_full();
    gap(4);

    cur_req = "R6";
    add_frame(3, 14);
    add_frame(0, 7);
    add_frame(2, 11);
    send_full();
    cur_req = "R7";
    gap(6);

    cur_req = "R8";
    add_idles(4);
    bq.push_back(B_S);
    for (int i = 0; i < 10; i++) bq.push_back({1'b0, 8'(i + 3)});
    send_full();
    gap(3);
    for (int i = 0; i < 5; i++) bq.push_back({1'b0, 8'(i + 90)});
    bq.push_back(B_T);
    add_idles(20);
    send_full();
    gap(4);

    cur_req = "R2";
    add_frame(7, 5);
    send_full();
    gap(3);

    cur_req = "R10";
    rd_en = 0;
    add_idles(8 * 12);
    send_full();
    gap(1);
    chk(fifo_full && overflow_err, "R10", "full with sticky overflow",
        {70'd0, fifo_full, overflow_err}, 72'b11);

    cur_req = "R9";
    rd_en = 1;
    gap(12);

    cur_req = "R11";
    gap(4);
    chk(fifo_empty && !out_valid, "R11", "read on empty", {70'd0, fifo_empty, out_valid}, 72'b10);

    rst = 1;
    gap(2);
    chk(fifo_empty && !fifo_full && !overflow_err && !out_valid, "R1", "reset clears overflow",
        {68'd0, fifo_empty, fifo_full, overflow_err, out_valid}, 72'b1000);
    rst = 0;
    gap(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule